// File: doc/BRIEF.md
# Card Interface Power Sequencer

This block sits between a memory-card host controller and the card pads and decides how the pads are driven while the card supply is being brought up or taken down. Software writes a small control word over a simple register bus. A 2-bit state field in that word selects one of three pad-drive states, and a separate option bit selects the direction polarity used by external level shifters.

In the power-cycle state, every card line is driven low. This stops the card from drawing supply current through its signal pins while its rail discharges. In the power-off state, every line is driven high and the host side is disconnected. In the on state, the block runs the card clock from a divider of the system clock. It keeps the command and data lines parked high until the card has seen a fixed number of rising card clock edges. After that, the command and data lines, and their enables, come straight from the host controller.

The expected software sequence is: reset, then power-cycle, then power-off, then wait at least a millisecond, then on. The block does not enforce that order. It only applies whichever legal state was last written.

Top module: `pwr_seq`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) puts the block in the off state (code 00) with the polarity bit 0, all pad lines high with their enables set, and `link_ready_o` low.
- R2: A write (`cfg_wr_i` high at a clock edge) with `cfg_wdata_i[1:0]` equal to 00 (off), 10 (power-cycle) or 11 (on) takes effect at that edge. `cfg_rdata_o[1:0]` then returns the state code, `cfg_rdata_o[4]` returns the polarity bit, and all other read bits are 0.
- R3: A write with `cfg_wdata_i[1:0]` = 01 leaves the state and all pad outputs unchanged.
- R4: In power-cycle, `pad_clk_o`, `pad_cmd_o` and every bit of `pad_dat_o` are 0, and every output enable is 1.
- R5: In off, `pad_clk_o`, `pad_cmd_o` and every bit of `pad_dat_o` are 1, and every output enable is 1.
- R6: In on, `pad_clk_o` is low at the edge that enters the state. It then inverts every CLK_HALF system clock edges, so that it is `(n / CLK_HALF) % 2` at the n-th edge after entry.
- R7: `link_ready_o` rises once `pad_clk_o` has made INIT_CLKS (default 74) rising transitions in the on state. Before that, command and data are driven 1 with their enables set.
- R8: While `link_ready_o` is high, `pad_cmd_o`, `pad_cmd_oe_o`, `pad_dat_o` and `pad_dat_oe_o` equal the corresponding host inputs.
- R9: Writing 11 while already on does not restart the clock divider or the edge count. Leaving on and returning restarts both from zero.
- R10: `dir_pol_o` equals `cfg_wdata_i[4]` of the last write, including a write of code 01, and no state change alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | REG_W | Control word: [1:0] state code, [4] polarity |
| cfg_rdata_o | output | REG_W | Readback of state code and polarity |
| host_cmd_i | input | 1 | Command value from host controller |
| host_cmd_oe_i | input | 1 | Command enable from host controller |
| host_dat_i | input | DATA_LINES | Data values from host controller |
| host_dat_oe_i | input | DATA_LINES | Data enables from host controller |
| pad_clk_o | output | 1 | Card clock pad |
| pad_cmd_o | output | 1 | Command pad value |
| pad_cmd_oe_o | output | 1 | Command pad enable |
| pad_dat_o | output | DATA_LINES | Data pad values |
| pad_dat_oe_o | output | DATA_LINES | Data pad enables |
| dir_pol_o | output | 1 | Level shifter direction polarity |
| link_ready_o | output | 1 | Initial clock run complete, host connected |

## Verification
The assertions check the following on every cycle: the fixed pad levels in power-cycle and off, that the readback never shows code 01, that a code 01 write never moves the state, that ready only exists in the on state and survives a repeated on write, and that the host passthrough holds while ready. The exact clock phase in the on state, the edge count at which ready rises, and the restart of that count after leaving and re-entering on can only be shown by the bench's scenarios. There, a per-cycle model predicts each pad value from the number of edges since entry.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'b00,
        PS_CYCLE = 2'b10,
        PS_ON    = 2'b11
    } pwr_state_e;

    // field positions inside the control word
    localparam int STATE_LSB = 0;
    localparam int POL_BIT   = 4;

    function automatic logic code_is_legal(input logic [1:0] code);
        return code != 2'b01;
    endfunction

endpackage

// File: rtl/pwr_state_reg.sv
module pwr_state_reg
    import pwr_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [1:0] code_i,
    input  logic       pol_i,
    output pwr_state_e state_o,
    output logic       pol_o
);

    typedef struct packed {
        pwr_state_e state;
        logic       pol;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            r_d.pol = pol_i;
            if (code_is_legal(code_i)) begin
                r_d.state = pwr_state_e'(code_i);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: PS_OFF, pol: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign pol_o   = r_q.pol;

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
    parameter int CLK_HALF  = 2,
    parameter int INIT_CLKS = 74
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic card_clk_o,
    output logic ready_o
);

    localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam int CNT_W = $clog2(INIT_CLKS + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(INIT_CLKS);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             ck;
        logic [CNT_W-1:0] rises;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d = '0;
        end else if (r_q.div == DIV_LAST) begin
            r_d.div = '0;
            r_d.ck  = ~r_q.ck;
            if (!r_q.ck && (r_q.rises != CNT_DONE)) begin
                r_d.rises = r_q.rises + 1'b1;
            end
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign card_clk_o = r_q.ck;
    assign ready_o    = run_i && (r_q.rises == CNT_DONE);

endmodule

// File: rtl/pad_drive_mux.sv
module pad_drive_mux
    import pwr_seq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  pwr_state_e       state_i,
    input  logic             ready_i,
    input  logic             card_clk_i,
    input  logic             host_cmd_i,
    input  logic             host_cmd_oe_i,
    input  logic [LINES-1:0] host_dat_i,
    input  logic [LINES-1:0] host_dat_oe_i,
    output logic             pad_clk_o,
    output logic             pad_cmd_o,
    output logic             pad_cmd_oe_o,
    output logic [LINES-1:0] pad_dat_o,
    output logic [LINES-1:0] pad_dat_oe_o
);

    logic park_level;
    logic pass_host;

    always_comb begin
        park_level = (state_i != PS_CYCLE);
        pass_host  = (state_i == PS_ON) && ready_i;
        pad_clk_o  = (state_i == PS_ON) ? card_clk_i : park_level;
        if (pass_host) begin
            pad_cmd_o    = host_cmd_i;
            pad_cmd_oe_o = host_cmd_oe_i;
        end else begin
            pad_cmd_o    = park_level;
            pad_cmd_oe_o = 1'b1;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_comb begin
            if (pass_host) begin
                pad_dat_o[i]    = host_dat_i[i];
                pad_dat_oe_o[i] = host_dat_oe_i[i];
            end else begin
                pad_dat_o[i]    = park_level;
                pad_dat_oe_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int DATA_LINES = 8,
    parameter int REG_W      = 8,
    parameter int CLK_HALF   = 2,
    parameter int INIT_CLKS  = 74
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_wr_i,
    input  logic [REG_W-1:0]      cfg_wdata_i,
    output logic [REG_W-1:0]      cfg_rdata_o,
    input  logic                  host_cmd_i,
    input  logic                  host_cmd_oe_i,
    input  logic [DATA_LINES-1:0] host_dat_i,
    input  logic [DATA_LINES-1:0] host_dat_oe_i,
    output logic                  pad_clk_o,
    output logic                  pad_cmd_o,
    output logic                  pad_cmd_oe_o,
    output logic [DATA_LINES-1:0] pad_dat_o,
    output logic [DATA_LINES-1:0] pad_dat_oe_o,
    output logic                  dir_pol_o,
    output logic                  link_ready_o
);

    pwr_state_e state;
    logic       pol;
    logic       card_clk;
    logic       ready;
    logic       unused_wdata;

    assign unused_wdata = ^{cfg_wdata_i[REG_W-1:POL_BIT+1], cfg_wdata_i[POL_BIT-1:STATE_LSB+2]};

    pwr_state_reg u_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .code_i  (cfg_wdata_i[STATE_LSB+1:STATE_LSB]),
        .pol_i   (cfg_wdata_i[POL_BIT]),
        .state_o (state),
        .pol_o   (pol)
    );

    card_clk_gen #(
        .CLK_HALF  (CLK_HALF),
        .INIT_CLKS (INIT_CLKS)
    ) u_clk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (state == PS_ON),
        .card_clk_o (card_clk),
        .ready_o    (ready)
    );

    pad_drive_mux #(
        .LINES (DATA_LINES)
    ) u_mux (
        .state_i       (state),
        .ready_i       (ready),
        .card_clk_i    (card_clk),
        .host_cmd_i    (host_cmd_i),
        .host_cmd_oe_i (host_cmd_oe_i),
        .host_dat_i    (host_dat_i),
        .host_dat_oe_i (host_dat_oe_i),
        .pad_clk_o     (pad_clk_o),
        .pad_cmd_o     (pad_cmd_o),
        .pad_cmd_oe_o  (pad_cmd_oe_o),
        .pad_dat_o     (pad_dat_o),
        .pad_dat_oe_o  (pad_dat_oe_o)
    );

    always_comb begin
        cfg_rdata_o = '0;
        cfg_rdata_o[STATE_LSB+1:STATE_LSB] = state;
        cfg_rdata_o[POL_BIT] = pol;
    end

    assign dir_pol_o    = pol;
    assign link_ready_o = ready;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int LINES = 8,
    parameter int REG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_wr_i,
    input logic [REG_W-1:0] cfg_wdata_i,
    input logic [REG_W-1:0] cfg_rdata_o,
    input logic             host_cmd_i,
    input logic             host_cmd_oe_i,
    input logic [LINES-1:0] host_dat_i,
    input logic [LINES-1:0] host_dat_oe_i,
    input logic             pad_clk_o,
    input logic             pad_cmd_o,
    input logic             pad_cmd_oe_o,
    input logic [LINES-1:0] pad_dat_o,
    input logic [LINES-1:0] pad_dat_oe_o,
    input logic             link_ready_o
);

    // R2
    legal_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_rdata_o[1:0] != 2'b01);

    // R3
    reserved_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && cfg_wdata_i[1:0] == 2'b01) |=> $stable(cfg_rdata_o[1:0]));

    // R4
    cycle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o[1:0] == 2'b10) |->
        (!pad_clk_o && !pad_cmd_o && pad_dat_o == '0 && pad_cmd_oe_o && (&pad_dat_oe_o)));

    // R5
    off_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o[1:0] == 2'b00) |->
        (pad_clk_o && pad_cmd_o && (&pad_dat_o) && pad_cmd_oe_o && (&pad_dat_oe_o)));

    // R7
    ready_only_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_ready_o |-> cfg_rdata_o[1:0] == 2'b11);

    // R8
    passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_ready_o |-> (pad_cmd_o == host_cmd_i && pad_cmd_oe_o == host_cmd_oe_i &&
                          pad_dat_o == host_dat_i && pad_dat_oe_o == host_dat_oe_i));

    // R9
    ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (link_ready_o && !(cfg_wr_i && (cfg_wdata_i[1:0] == 2'b00 || cfg_wdata_i[1:0] == 2'b10)))
        |=> link_ready_o);

endmodule

bind pwr_seq pwr_seq_chk #(
    .LINES (DATA_LINES),
    .REG_W (REG_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .host_cmd_i    (host_cmd_i),
    .host_cmd_oe_i (host_cmd_oe_i),
    .host_dat_i    (host_dat_i),
    .host_dat_oe_i (host_dat_oe_i),
    .pad_clk_o     (pad_clk_o),
    .pad_cmd_o     (pad_cmd_o),
    .pad_cmd_oe_o  (pad_cmd_oe_o),
    .pad_dat_o     (pad_dat_o),
    .pad_dat_oe_o  (pad_dat_oe_o),
    .link_ready_o  (link_ready_o)
);

// File: tb/sim_pwr_seq.sv
`timescale 1ns/1ps
module sim_pwr_seq;

    localparam int LINES = 8;
    localparam int RW    = 8;
    localparam int HALF  = 2;
    localparam int INIT  = 74;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr = 1'b0;
    logic [RW-1:0]    wdata = '0;
    logic [RW-1:0]    rdata;
    logic             hcmd = 1'b0, hcmd_oe = 1'b0;
    logic [LINES-1:0] hdat = '0, hdat_oe = '0;
    logic             p_clk, p_cmd, p_cmd_oe, pol, rdy;
    logic [LINES-1:0] p_dat, p_dat_oe;

    always #4 clk = ~clk;

    pwr_seq #(.DATA_LINES(LINES), .REG_W(RW), .CLK_HALF(HALF), .INIT_CLKS(INIT)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata), .host_cmd_i(hcmd), .host_cmd_oe_i(hcmd_oe),
        .host_dat_i(hdat), .host_dat_oe_i(hdat_oe), .pad_clk_o(p_clk),
        .pad_cmd_o(p_cmd), .pad_cmd_oe_o(p_cmd_oe), .pad_dat_o(p_dat),
        .pad_dat_oe_o(p_dat_oe), .dir_pol_o(pol), .link_ready_o(rdy)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    string phase   = "R1";

    // behavioural model: state code, polarity, edges since entering on
    int m_st  = 0;
    int m_pol = 0;
    int m_n   = -1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_pol = 0; m_n = -1;
        end else begin
            automatic bit was_on = (m_st == 3);
            if (was_on) m_n++;
            if (wr) begin
                automatic int code = int'(wdata[1:0]);
                m_pol = int'(wdata[4]);
                if (code != 1) begin
                    if (code == 3 && !was_on) m_n = 0;
                    else if (code != 3) m_n = -1;
                    m_st = code;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s, phase %s): actual %h expected %h", req, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic             e_clk, e_cmd, e_cmd_oe, e_rdy;
        logic [LINES-1:0] e_dat, e_dat_oe;
        logic [RW-1:0]    e_rd;
        vectors++;
        e_rd = '0;
        e_rd[1:0] = m_st[1:0];
        e_rd[4]   = m_pol[0];
        e_rdy = 1'b0;
        if (m_st == 2) begin
            e_clk = 0; e_cmd = 0; e_dat = '0; e_cmd_oe = 1; e_dat_oe = '1;
        end else if (m_st == 0) begin
            e_clk = 1; e_cmd = 1; e_dat = '1; e_cmd_oe = 1; e_dat_oe = '1;
        end else begin
            e_clk = ((m_n / HALF) % 2) == 1;
            e_rdy = ((m_n + HALF) / (2 * HALF)) >= INIT;
            if (e_rdy) begin
                e_cmd = hcmd; e_cmd_oe = hcmd_oe; e_dat = hdat; e_dat_oe = hdat_oe;
            end else begin
                e_cmd = 1; e_cmd_oe = 1; e_dat = '1; e_dat_oe = '1;
            end
        end
        chk("R2", "readback", 32'(rdata), 32'(e_rd));
        chk("R10", "polarity", 32'(pol), 32'(m_pol[0]));
        chk(m_st == 3 ? "R6" : (m_st == 2 ? "R4" : "R5"), "card clock", 32'(p_clk), 32'(e_clk));
        chk("R7", "ready", 32'(rdy), 32'(e_rdy));
        chk(e_rdy ? "R8" : "R7", "cmd", 32'({p_cmd, p_cmd_oe}), 32'({e_cmd, e_cmd_oe}));
        chk(e_rdy ? "R8" : "R7", "data", 32'({p_dat, p_dat_oe}), 32'({e_dat, e_dat_oe}));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            {hcmd, hcmd_oe, hdat, hdat_oe} = {hcmd, hcmd_oe, hdat, hdat_oe} * 18'd1103 + 18'd12345;
        end
    endtask

    task automatic write(logic [1:0] code, logic p);
        @(posedge clk); #2;
        wr = 1'b1;
        wdata = '0;
        wdata[1:0] = code;
        wdata[4] = p;
        @(posedge clk); #2;
        wr = 1'b0;
        wdata = 8'hE8;
    endtask

    initial begin
        // R1: reset state observed while reset is held and just after release
        step(3);
        rst_n = 1'b1;
        step(3);
        phase = "R4";
        write(2'b10, 1'b0);
        step(5);
        phase = "R5/R10";
        write(2'b00, 1'b1);
        step(5);
        phase = "R3";
        write(2'b01, 1'b0);
        step(4);
        phase = "R6/R7/R8";
        write(2'b11, 1'b0);
        step(330);
        phase = "R9 repeat on";
        write(2'b11, 1'b1);
        step(20);
        phase = "R3 in on";
        write(2'b01, 1'b1);
        step(10);
        phase = "R9 restart";
        write(2'b00, 1'b0);
        step(6);
        write(2'b11, 1'b0);
        step(150);
        phase = "R4 from on";
        write(2'b10, 1'b1);
        step(6);
        write(2'b11, 1'b1);
        step(320);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule